// File: doc/BRIEF.md
# Two-Level Opcode Decoder

This block turns one instruction byte of a small 8-bit processor into the control fields that the rest of the core needs. The decoding happens in two stages. The upper nibble picks a primary operation family. The lower nibble then either picks a variant inside that family or has to be zero. The outputs are the instruction class, the ALU operation, the addressing mode, the selection between an immediate and a register operand, the jump condition, the number of operand bytes that follow the opcode, and a result-write enable.

The decoder is purely combinational, and the fetch and execute stages sample its outputs directly. Exactly 46 of the 256 byte values are legal. Any other byte raises `illegal_o`, and every other output is then forced to zero. As a result, a bad byte can never start a write, and it can never ask for operand bytes.

Top module: `opcode_decoder`

## Requirements
- R1: High nibbles 0x0, 0x1, 0xB, 0xE and 0xF accept only low nibble 0. They give class 0 (nop), 1 (move), 6 (shift, alu op 7), 8 (return) and 9 (halt), with addressing mode 0 and no operand bytes.
- R2: High nibble 0x2 is the load family, class 2. Each legal low nibble selects one form:
  - low 0 is load immediate (imm 1, mode 0);
  - low 1 is mode 1, zero page indexed by a register;
  - low 2 is mode 2, zero page with a byte address;
  - low 3 is mode 3, absolute through a register pair;
  - low 4 is mode 4, absolute with a 16-bit address.
  - Low nibbles 5 to F are illegal.
- R3: High nibble 0x3 is the store family, class 3. Low nibbles 0, 1, 2 and 3 select modes 1, 2, 3 and 4 respectively. Low nibbles 4 to F are illegal.
- R4: High nibbles 0x4 to 0xA give class 4 with alu op codes 0 (add), 1 (adc), 2 (sub), 3 (sbb), 4 (and), 5 (or) and 6 (xor), in that order. High nibble 0xC gives class 5 (unsigned compare) with alu op 2.
- R5: For the ALU and compare families, low nibble 0 selects the register operand (imm 0) and low nibble 1 selects the 8-bit immediate operand (imm 1). Low nibbles 2 to F are illegal.
- R6: High nibble 0xD gives class 7 (jump) for all 16 low nibbles. The jump condition equals low nibble bits [3:1]. An even low nibble gives mode 3 and an odd low nibble gives mode 4.
- R7: `extra_bytes_o` is 2 for mode 4. It is 1 for an 8-bit immediate operand or for mode 2. It is 0 otherwise.
- R8: `wr_en_o` is 1 for move, load, the ALU class and shift. It is 0 for store, compare, jump, return, nop and halt.
- R9: Exactly 46 opcodes are legal. For every other opcode, `illegal_o` is 1 and all other outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 8 | Instruction byte |
| cls_o | output | 4 | Instruction class |
| alu_op_o | output | 3 | ALU operation |
| addr_mode_o | output | 3 | Addressing mode |
| imm_sel_o | output | 1 | Second operand or load value is an immediate |
| jmp_cond_o | output | 3 | Jump condition select |
| extra_bytes_o | output | 2 | Operand bytes following the opcode |
| wr_en_o | output | 1 | Result write enable |
| illegal_o | output | 1 | Undefined opcode |

## Verification
The in-line assertions check cross-field consistency on every input change:
- an illegal opcode leaves every other output quiet;
- mode 4 always costs two operand bytes;
- a write is only enabled for the result-producing classes;
- a compare never writes.

Only the bench's full sweep of the 256 bytes can show the things the assertions cannot:
- that each individual code lands on the right class, operation and mode;
- that the legal set is exactly 46 bytes;
- that each jump's condition matches its low nibble.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int OPC_W = 8;
  localparam int NIB_W = OPC_W / 2;

  typedef enum logic [3:0] {
    CLS_NOP = 4'd0, CLS_MOVE = 4'd1, CLS_LOAD = 4'd2, CLS_STORE = 4'd3,
    CLS_ALU = 4'd4, CLS_CMP = 4'd5, CLS_SHIFT = 4'd6, CLS_JUMP = 4'd7,
    CLS_RET = 4'd8, CLS_HALT = 4'd9
  } cls_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_ADC = 3'd1, ALU_SUB = 3'd2, ALU_SBB = 3'd3,
    ALU_AND = 3'd4, ALU_OR = 3'd5, ALU_XOR = 3'd6, ALU_SHR = 3'd7
  } alu_e;

  typedef enum logic [2:0] {
    AM_NONE = 3'd0, AM_ZP_REG = 3'd1, AM_ZP_DIR = 3'd2,
    AM_ABS_REG = 3'd3, AM_ABS_DIR = 3'd4
  } am_e;
endpackage

// File: rtl/opdec_primary.sv
module opdec_primary
  import opdec_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic [NIB_W-1:0] hi_i,
  output cls_e             cls_o,
  output alu_e             alu_o
);
  always_comb begin
    cls_o = CLS_NOP;
    alu_o = ALU_ADD;
    case (hi_i)
      4'h0: cls_o = CLS_NOP;
      4'h1: cls_o = CLS_MOVE;
      4'h2: cls_o = CLS_LOAD;
      4'h3: cls_o = CLS_STORE;
      4'h4: begin cls_o = CLS_ALU; alu_o = ALU_ADD; end
      4'h5: begin cls_o = CLS_ALU; alu_o = ALU_ADC; end
      4'h6: begin cls_o = CLS_ALU; alu_o = ALU_SUB; end
      4'h7: begin cls_o = CLS_ALU; alu_o = ALU_SBB; end
      4'h8: begin cls_o = CLS_ALU; alu_o = ALU_AND; end
      4'h9: begin cls_o = CLS_ALU; alu_o = ALU_OR;  end
      4'hA: begin cls_o = CLS_ALU; alu_o = ALU_XOR; end
      4'hB: begin cls_o = CLS_SHIFT; alu_o = ALU_SHR; end
      4'hC: begin cls_o = CLS_CMP; alu_o = ALU_SUB; end
      4'hD: cls_o = CLS_JUMP;
      4'hE: cls_o = CLS_RET;
      default: cls_o = CLS_HALT;
    endcase
  end

  // families that use no ALU op must leave it at zero
  always_comb begin
    if (!$isunknown(hi_i))
      AST_ALU_IDLE: assert (cls_o inside {CLS_ALU, CLS_CMP, CLS_SHIFT} || alu_o == ALU_ADD); // R4
  end
endmodule

// File: rtl/opdec_mode.sv
module opdec_mode
  import opdec_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  cls_e             cls_i,
  input  logic [NIB_W-1:0] lo_i,
  output logic             valid_o,
  output am_e              mode_o,
  output logic             imm_o,
  output logic [1:0]       extra_o,
  output logic [2:0]       cond_o
);
  always_comb begin
    valid_o = 1'b0;
    mode_o  = AM_NONE;
    imm_o   = 1'b0;
    extra_o = 2'd0;
    cond_o  = 3'd0;
    case (cls_i)
      CLS_LOAD: begin
        valid_o = 1'b1;
        case (lo_i)
          4'h0: begin imm_o = 1'b1; extra_o = 2'd1; end
          4'h1: mode_o = AM_ZP_REG;
          4'h2: begin mode_o = AM_ZP_DIR; extra_o = 2'd1; end
          4'h3: mode_o = AM_ABS_REG;
          4'h4: begin mode_o = AM_ABS_DIR; extra_o = 2'd2; end
          default: valid_o = 1'b0;
        endcase
      end
      CLS_STORE: begin
        valid_o = 1'b1;
        case (lo_i)
          4'h0: mode_o = AM_ZP_REG;
          4'h1: begin mode_o = AM_ZP_DIR; extra_o = 2'd1; end
          4'h2: mode_o = AM_ABS_REG;
          4'h3: begin mode_o = AM_ABS_DIR; extra_o = 2'd2; end
          default: valid_o = 1'b0;
        endcase
      end
      CLS_ALU, CLS_CMP: begin
        valid_o = (lo_i == 4'h0) || (lo_i == 4'h1);
        imm_o   = (lo_i == 4'h1);
        extra_o = (lo_i == 4'h1) ? 2'd1 : 2'd0;
      end
      CLS_JUMP: begin
        valid_o = 1'b1;
        cond_o  = lo_i[NIB_W-1:1];
        mode_o  = lo_i[0] ? AM_ABS_DIR : AM_ABS_REG;
        extra_o = lo_i[0] ? 2'd2 : 2'd0;
      end
      default: valid_o = (lo_i == '0); // single-form families
    endcase
  end

  always_comb begin
    if (!$isunknown(lo_i)) begin
      AST_DIR16_TWO: assert (!(valid_o && mode_o == AM_ABS_DIR) || extra_o == 2'd2); // R7
      AST_JMP_ALWAYS_OK: assert (cls_i != CLS_JUMP || valid_o); // R6
    end
  end
endmodule

// File: rtl/opcode_decoder.sv
module opcode_decoder
  import opdec_pkg::*;
#(
  parameter int OPC_W_P = OPC_W
) (
  input  logic [OPC_W_P-1:0] opcode_i,
  output logic [3:0]         cls_o,
  output logic [2:0]         alu_op_o,
  output logic [2:0]         addr_mode_o,
  output logic               imm_sel_o,
  output logic [2:0]         jmp_cond_o,
  output logic [1:0]         extra_bytes_o,
  output logic               wr_en_o,
  output logic               illegal_o
);
  localparam int NW = OPC_W_P / 2;

  cls_e       cls;
  alu_e       alu;
  am_e        mode;
  logic       valid, imm;
  logic [1:0] extra;
  logic [2:0] cond;

  opdec_primary #(.NIB_W(NW)) u_primary (
    .hi_i (opcode_i[OPC_W_P-1:NW]),
    .cls_o(cls),
    .alu_o(alu)
  );

  opdec_mode #(.NIB_W(NW)) u_mode (
    .cls_i  (cls),
    .lo_i   (opcode_i[NW-1:0]),
    .valid_o(valid),
    .mode_o (mode),
    .imm_o  (imm),
    .extra_o(extra),
    .cond_o (cond)
  );

  // illegal bytes are fully quiet
  always_comb begin
    illegal_o     = !valid;
    cls_o         = valid ? cls : CLS_NOP;
    alu_op_o      = valid ? alu : ALU_ADD;
    addr_mode_o   = valid ? mode : AM_NONE;
    imm_sel_o     = valid & imm;
    jmp_cond_o    = valid ? cond : 3'd0;
    extra_bytes_o = valid ? extra : 2'd0;
    wr_en_o       = valid & (cls inside {CLS_MOVE, CLS_LOAD, CLS_ALU, CLS_SHIFT});
  end

  always_comb begin
    if (!$isunknown(opcode_i)) begin
      AST_ILLEGAL_QUIET: assert (!illegal_o || (cls_o == 4'd0 && alu_op_o == 3'd0 &&
        addr_mode_o == 3'd0 && !imm_sel_o && jmp_cond_o == 3'd0 &&
        extra_bytes_o == 2'd0 && !wr_en_o)); // R9
      AST_WR_CLASS: assert (!wr_en_o || cls_o inside {4'd1, 4'd2, 4'd4, 4'd6}); // R8
      AST_CMP_NO_WR: assert (cls_o != 4'd5 || !wr_en_o); // R8
      AST_IMM_ONE_BYTE: assert (!imm_sel_o || extra_bytes_o == 2'd1); // R7
      AST_COND_JUMP_ONLY: assert (jmp_cond_o == 3'd0 || cls_o == 4'd7); // R6
    end
  end
endmodule

// File: tb/opcode_decoder_test.sv
module opcode_decoder_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic [7:0] opcode;
  logic [3:0] cls;
  logic [2:0] alu_op, mode, cond;
  logic       imm, wr, ill;
  logic [1:0] extra;

  int total = 0;
  int bad = 0;
  int legal_cnt = 0;
  bit done = 1'b0;

  opcode_decoder uut (
    .opcode_i(opcode), .cls_o(cls), .alu_op_o(alu_op), .addr_mode_o(mode),
    .imm_sel_o(imm), .jmp_cond_o(cond), .extra_bytes_o(extra),
    .wr_en_o(wr), .illegal_o(ill)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s op=%02h act=%0d exp=%0d", req, what, opcode, act, exp);
    end
  endtask

  // reference built from the requirement text
  task automatic expect_for(input logic [7:0] op, output int e_ok, output int e_cls,
                            output int e_alu, output int e_mode, output int e_imm,
                            output int e_cond, output int e_ext, output int e_wr,
                            output string req);
    int hi, lo;
    hi = int'(op[7:4]); lo = int'(op[3:0]);
    e_ok = 0; e_cls = 0; e_alu = 0; e_mode = 0; e_imm = 0; e_cond = 0; e_ext = 0; e_wr = 0;
    req = "R1";
    if (hi == 0 || hi == 1 || hi == 11 || hi == 14 || hi == 15) begin
      e_ok = (lo == 0);
      e_cls = (hi == 0) ? 0 : (hi == 1) ? 1 : (hi == 11) ? 6 : (hi == 14) ? 8 : 9;
      e_alu = (hi == 11) ? 7 : 0;
      e_wr = (hi == 1 || hi == 11) ? 1 : 0;
    end else if (hi == 2) begin
      req = "R2"; e_ok = (lo <= 4); e_cls = 2; e_wr = 1;
      e_mode = lo;
      e_imm = (lo == 0);
      e_ext = (lo == 0 || lo == 2) ? 1 : (lo == 4) ? 2 : 0;
    end else if (hi == 3) begin
      req = "R3"; e_ok = (lo <= 3); e_cls = 3;
      e_mode = lo + 1;
      e_ext = (lo == 1) ? 1 : (lo == 3) ? 2 : 0;
    end else if ((hi >= 4 && hi <= 10) || hi == 12) begin
      req = (lo <= 1) ? "R4" : "R5";
      e_ok = (lo <= 1);
      e_cls = (hi == 12) ? 5 : 4;
      e_alu = (hi == 12) ? 2 : hi - 4;
      e_imm = lo; e_ext = lo;
      e_wr = (hi == 12) ? 0 : 1;
    end else begin
      req = "R6"; e_ok = 1; e_cls = 7;
      e_cond = lo / 2;
      e_mode = (lo % 2 == 1) ? 4 : 3;
      e_ext = (lo % 2 == 1) ? 2 : 0;
    end
    if (e_ok == 0) begin
      e_cls = 0; e_alu = 0; e_mode = 0; e_imm = 0; e_cond = 0; e_ext = 0; e_wr = 0;
    end
  endtask

  initial begin
    opcode = 8'h00;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset state: nop byte decodes as a legal nop
    chk("R1", "reset_cls", int'(cls), 0);
    chk("R9", "reset_ill", int'(ill), 0);
    chk("R8", "reset_wr", int'(wr), 0);

    for (int i = 0; i < 256; i++) begin
      int e_ok, e_cls, e_alu, e_mode, e_imm, e_cond, e_ext, e_wr;
      string req;
      @(posedge clk);
      opcode = 8'(i);
      expect_for(8'(i), e_ok, e_cls, e_alu, e_mode, e_imm, e_cond, e_ext, e_wr, req);
      @(negedge clk);
      if (ill == 1'b0) legal_cnt++;
      chk("R9", "illegal", int'(ill), 1 - e_ok);
      chk(req, "cls", int'(cls), e_cls);
      chk(req, "alu_op", int'(alu_op), e_alu);
      chk(req, "mode", int'(mode), e_mode);
      chk((req == "R4") ? "R5" : req, "imm_sel", int'(imm), e_imm);
      chk(req, "cond", int'(cond), e_cond);
      chk("R7", "extra_bytes", int'(extra), e_ext);
      chk("R8", "wr_en", int'(wr), e_wr);
    end
    chk("R9", "legal_count", legal_cnt, 46);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule